// File: doc/BRIEF.md
# Multiprocessor-capable asynchronous serial receiver

This block receives asynchronous serial frames from a single line and hands each finished character to a processor through a small set of registered outputs. It handles two frame lengths. One is a start bit, eight data bits and a stop bit. The other is a start bit, eight data bits, a ninth bit and a stop bit. Every bit is timed by an external sampling tick that runs at sixteen times the bit rate. The receiver decides each bit by a majority vote over three samples taken at the middle of the bit. A start bit that does not hold low through its middle is thrown away as line noise.

Two optional functions sit on top of plain reception. The first is a stop-bit check. When it is on, a stop bit that reads low sets an error flag that stays set until software clears it. Turning the check on also moves the moment the completion flag is raised, from the last data bit to the stop bit. The second is address filtering for shared multi-drop links. With it enabled, a frame is delivered only if it is marked as an address frame and its byte matches either the node's masked individual address or the broadcast address. The broadcast address is derived from the address and mask registers. Frames that fail the filter leave every output untouched. Software acknowledges a frame with a one-cycle clear strobe. The receiver will not begin a new frame while the previous one is still unacknowledged.

Top module: `uart_addr_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rx_data` and `rx_bit9` read zero and `rx_flag` and `fe_flag` read 0. The stored node address and mask are external inputs, and tying both to zero makes every byte match.
- R2: `rxd` passes through a two-stage synchronizer. The receiver accepts a start bit only in idle, on a tick where the synchronized line is low. Each bit spans 16 ticks. Data bits arrive least significant first. Each bit takes the majority of the synchronized samples at ticks 7, 8 and 9 of the bit, counted from 0. A single disagreeing sample among the three does not change the result.
- R3: A start bit whose majority vote is 1 is dropped. The receiver returns to idle and leaves every output unchanged.
- R4: `mode_sel` selects the frame length: 1 is the 8-bit frame, and 2 or 3 is the 9-bit frame. With `fe_chk_en` low and no mode-1 address filtering, a frame completes at the vote of its last data bit, which is D7 in mode 1 and the ninth bit in modes 2 and 3. `rx_bit9` receives the ninth bit in modes 2 and 3, and 0 for a mode-1 frame completed at D7.
- R5: With `fe_chk_en` high, a frame completes at the vote of its stop bit. In mode 1, `rx_bit9` then receives the stop bit value.
- R6: With `fe_chk_en` high, a stop bit that votes 0 sets `fe_flag` in modes 1, 2 and 3, whether or not the address filter accepts the frame. With `fe_chk_en` low, `fe_flag` never sets.
- R7: `fe_flag` stays set until a `fe_clr` pulse or reset clears it. Later frames with a valid stop bit leave it at 1.
- R8: With `mp_en` high, an address frame is accepted if its byte equals `node_addr` in every bit position where `node_mask` is 1. Frames that are not accepted leave `rx_data`, `rx_bit9` and `rx_flag` unchanged.
- R9: With `mp_en` high, an address frame is also accepted if its byte has a 1 in every bit position where (`node_addr` OR `node_mask`) is 1.
- R10: In modes 2 and 3 with `mp_en` high, only frames whose ninth bit is 1 count as address frames. A frame with a ninth bit of 0 is dropped, and `rx_flag` is not raised.
- R11: In mode 1 with `mp_en` high, the stop bit acts as the ninth bit. Such a frame completes at the stop-bit vote and is accepted only if the stop bit is 1 and the address matches.
- R12: With `mode_sel` = 0 the receiver stays idle and does not react to the line. Setting `mp_en` in this mode changes nothing.
- R13: An accepted frame sets `rx_flag`, and the flag holds until a `ri_clr` pulse. While `rx_flag` is 1, no start bit is taken, and a frame sent during that time leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | Sampling tick at 16 times the bit rate |
| mode_sel | input | 2 | 0 receiver off, 1 8-bit frame, 2/3 9-bit frame |
| mp_en | input | 1 | Enables address filtering |
| fe_chk_en | input | 1 | Enables the stop-bit check and late completion |
| node_addr | input | DATA_W | Node address |
| node_mask | input | DATA_W | Address mask, 1 = bit compared |
| ri_clr | input | 1 | Clears rx_flag |
| fe_clr | input | 1 | Clears fe_flag |
| rx_data | output | DATA_W | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit (or stop bit) of the last accepted frame |
| rx_flag | output | 1 | Frame received, awaiting acknowledge |
| fe_flag | output | 1 | Sticky stop-bit error |

## Verification
The bench builds the receiver with its defaults: an 8-bit byte, 16 ticks per bit and a two-stage synchronizer. It holds the tick high, so every clock is a sample point. With those values, the vote of bit n lands a fixed 12 + 16n clocks after the first low line sample. The reference model can therefore name the exact clock on which the completion flag or the error flag must move. Compared on every clock, this separates completion at the last data bit from completion at the stop bit, which is one bit period later. The short frames also make it practical to cover single-sample line disturbances, masked and broadcast matches, and frames sent while the previous one is still unacknowledged.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] MODE_SYNC = 2'd0;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic tick,
  output logic line_s,
  output logic vote
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic [1:0]             hist_d;

  if (SYNC_STAGES > 1) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
  end else begin : g_single
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= rxd;
    end
  end

  assign line_s = sync_q[SYNC_STAGES-1];

  // Two previous samples plus the current one form the vote window.
  always_comb begin
    hist_d = hist_q;
    if (tick) hist_d = {hist_q[0], line_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 2'b11;
    else        hist_q <= hist_d;
  end

  assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_s) | (hist_q[0] & line_s);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_s,
  input  logic              vote,
  input  logic [1:0]        mode_sel,
  input  logic              mp_en,
  input  logic              fe_chk_en,
  input  logic              hold,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_b9,
  output logic              commit,
  output logic              stop_bad
);
  localparam int              CNT_W    = $clog2(OVS);
  localparam int              IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] VOTE_AT  = CNT_W'(OVS / 2 + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  shift_q, shift_d;
  logic               ninth_q, ninth_d;
  logic               nine_q, nine_d;
  logic               early_q, early_d;
  logic               at_vote, at_last, last_vote, stop_vote;

  assign at_vote = (cnt_q == VOTE_AT);
  assign at_last = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    ninth_d = ninth_q;
    nine_d  = nine_q;
    early_d = early_q;
    if (tick) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          cnt_d = '0;
          if (!line_s && !hold && mode_sel != MODE_SYNC) begin
            state_d = RX_START;
            nine_d  = mode_sel[1];
            // Mode-1 filtering needs the stop bit, so it forces late completion.
            early_d = !fe_chk_en && !(!mode_sel[1] && mp_en);
          end
        end
        RX_START: begin
          if (at_vote && vote) state_d = RX_IDLE;
          else if (at_last) begin
            state_d = RX_DATA;
            idx_d   = '0;
          end
        end
        RX_DATA: begin
          if (at_vote) shift_d = {vote, shift_q[DATA_W-1:1]};
          if (at_last) begin
            if (idx_q == IDX_LAST) state_d = nine_q ? RX_NINTH : RX_STOP;
            idx_d = idx_q + 1'b1;
          end
        end
        RX_NINTH: begin
          if (at_vote) ninth_d = vote;
          if (at_last) state_d = RX_STOP;
        end
        RX_STOP: if (at_vote) state_d = RX_IDLE;
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      ninth_q <= 1'b0;
      nine_q  <= 1'b0;
      early_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      ninth_q <= ninth_d;
      nine_q  <= nine_d;
      early_q <= early_d;
    end
  end

  assign last_vote = tick && at_vote &&
                     ((state_q == RX_DATA && idx_q == IDX_LAST && !nine_q) || state_q == RX_NINTH);
  assign stop_vote = tick && at_vote && (state_q == RX_STOP);
  assign commit    = early_q ? last_vote : stop_vote;
  assign stop_bad  = stop_vote && !vote;

  assign frame_data = (state_q == RX_DATA) ? {vote, shift_q[DATA_W-1:1]} : shift_q;
  assign frame_b9   = nine_q ? ((state_q == RX_NINTH) ? vote : ninth_q)
                             : ((state_q == RX_STOP)  ? vote : 1'b0);

  a_r13_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && hold) |=> (state_q == RX_IDLE));

  a_r12_sync_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && mode_sel == MODE_SYNC) |=> (state_q == RX_IDLE));

  a_r3_glitch_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && at_vote && vote) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] mask,
  output logic              hit
);
  logic [DATA_W-1:0] bcast;
  logic              given_hit, bcast_hit;

  assign bcast     = addr | mask;
  assign given_hit = ~|((rx_byte ^ addr) & mask);
  assign bcast_hit = ((rx_byte & bcast) == bcast);
  assign hit       = given_hit | bcast_hit;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              baud_tick,
  input  logic [1:0]        mode_sel,
  input  logic              mp_en,
  input  logic              fe_chk_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic [DATA_W-1:0] node_mask,
  input  logic              ri_clr,
  input  logic              fe_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_bit9,
  output logic              rx_flag,
  output logic              fe_flag
);
  logic              line_s, vote, commit, stop_bad, frame_b9, addr_hit, load;
  logic [DATA_W-1:0] frame_data;
  logic [DATA_W-1:0] data_q, data_d;
  logic              b9_q, b9_d, flag_q, flag_d, fe_q, fe_d;

  rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(baud_tick),
    .line_s(line_s), .vote(vote)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line_s(line_s), .vote(vote),
    .mode_sel(mode_sel), .mp_en(mp_en), .fe_chk_en(fe_chk_en), .hold(flag_q),
    .frame_data(frame_data), .frame_b9(frame_b9), .commit(commit), .stop_bad(stop_bad)
  );

  rx_addr_match #(.DATA_W(DATA_W)) u_match (
    .rx_byte(frame_data), .addr(node_addr), .mask(node_mask), .hit(addr_hit)
  );

  assign load = commit && (!mp_en || (frame_b9 && addr_hit));

  always_comb begin
    data_d = load ? frame_data : data_q;
    b9_d   = load ? frame_b9   : b9_q;
    flag_d = load ? 1'b1 : (ri_clr ? 1'b0 : flag_q);
    fe_d   = (fe_chk_en && stop_bad) ? 1'b1 : (fe_clr ? 1'b0 : fe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      b9_q   <= 1'b0;
      flag_q <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      b9_q   <= b9_d;
      flag_q <= flag_d;
      fe_q   <= fe_d;
    end
  end

  assign rx_data = data_q;
  assign rx_bit9 = b9_q;
  assign rx_flag = flag_q;
  assign fe_flag = fe_q;

  a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !fe_clr) |=> fe_q);

  a_r6_fe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_q) |-> $past(fe_chk_en));

  a_r13_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ri_clr) |=> flag_q);

  a_r8_data_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(load));
endmodule

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b1;
  logic [1:0] mode_sel = 2'd1;
  logic       mp_en = 1'b0;
  logic       fe_chk_en = 1'b0;
  logic [7:0] node_addr = 8'h00;
  logic [7:0] node_mask = 8'h00;
  logic       ri_clr = 1'b0;
  logic       fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_flag, fe_flag;

  uart_addr_rx i_uart_addr_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick), .mode_sel(mode_sel),
    .mp_en(mp_en), .fe_chk_en(fe_chk_en), .node_addr(node_addr), .node_mask(node_mask),
    .ri_clr(ri_clr), .fe_clr(fe_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .fe_flag(fe_flag)
  );

  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string req = "R1";
  logic [7:0] e_data = 8'h00;
  logic       e_b9 = 1'b0, e_ri = 1'b0, e_fe = 1'b0;

  task automatic compare();
    n_chk++;
    if (rx_data !== e_data || rx_bit9 !== e_b9 || rx_flag !== e_ri || fe_flag !== e_fe) begin
      n_bad++;
      $display("FAIL %s: data=%h b9=%b ri=%b fe=%b expected data=%h b9=%b ri=%b fe=%b",
               req, rx_data, rx_bit9, rx_flag, fe_flag, e_data, e_b9, e_ri, e_fe);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      rxd = 1'b1;
    end
  endtask

  task automatic clear_ri();
    @(negedge clk); compare(); ri_clr = 1'b1;
    @(negedge clk); e_ri = 1'b0; compare(); ri_clr = 1'b0;
  endtask

  task automatic clear_fe();
    @(negedge clk); compare(); fe_clr = 1'b1;
    @(negedge clk); e_fe = 1'b0; compare(); fe_clr = 1'b0;
  endtask

  // Behavioural model: bit n is voted 12+16n clocks after the first low line clock,
  // so the result is visible at the negedge of iteration 13+16n.
  task automatic send_frame(input int md, input logic [7:0] d, input logic b9,
                            input logic stp, input int flip);
    bit         nine = (md >= 2);
    int         s = nine ? 10 : 9;
    int         cbit;
    logic [10:0] bits;
    logic [7:0] bc = node_addr | node_mask;
    logic       qual, match, blocked, acc;
    mode_sel = md[1:0];
    bits = '1;
    bits[0] = 1'b0;
    bits[8:1] = d;
    if (nine) begin bits[9] = b9; bits[10] = stp; end
    else bits[9] = stp;
    cbit    = (fe_chk_en || (!nine && mp_en)) ? s : (nine ? 9 : 8);
    qual    = nine ? b9 : ((cbit == s) ? stp : 1'b0);
    match   = (((d ^ node_addr) & node_mask) == 8'h00) || ((d & bc) == bc);
    blocked = e_ri || (md == 0);
    acc     = !blocked && (!mp_en || (qual && match));
    for (int k = 0; k < 16 * (s + 1) + 6; k++) begin
      @(negedge clk);
      if (acc && k == 13 + 16 * cbit) begin e_data = d; e_b9 = qual; e_ri = 1'b1; end
      if (!blocked && fe_chk_en && !stp && k == 13 + 16 * s) e_fe = 1'b1;
      compare();
      if (k < 16 * (s + 1)) begin
        rxd = bits[k / 16];
        if (k == 16 * flip + 9) rxd = ~rxd;
      end else rxd = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    req = "R1";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(8);

    req = "R4"; send_frame(1, 8'hA5, 1'b0, 1'b1, -1); clear_ri();
    send_frame(2, 8'h3C, 1'b1, 1'b1, -1); clear_ri();
    req = "R4_stop0_nofe"; send_frame(1, 8'h0F, 1'b0, 1'b0, -1); clear_ri();

    req = "R2"; send_frame(3, 8'h96, 1'b0, 1'b1, 3); clear_ri();
    send_frame(1, 8'h01, 1'b0, 1'b1, 8); clear_ri();

    req = "R5"; fe_chk_en = 1'b1;
    send_frame(1, 8'h5A, 1'b0, 1'b1, -1); clear_ri();
    send_frame(2, 8'hC3, 1'b0, 1'b1, -1); clear_ri();

    req = "R6"; send_frame(2, 8'h11, 1'b0, 1'b0, -1); clear_ri();
    req = "R7"; send_frame(1, 8'h22, 1'b0, 1'b1, -1); clear_ri();
    idle(5); clear_fe();
    req = "R6_mode1"; send_frame(1, 8'h44, 1'b0, 1'b0, -1); clear_ri(); clear_fe();
    req = "R6_disabled"; fe_chk_en = 1'b0;
    send_frame(3, 8'h77, 1'b1, 1'b0, -1); clear_ri();

    req = "R3";
    for (int k = 0; k < 24; k++) begin
      @(negedge clk); compare(); rxd = (k < 4) ? 1'b0 : 1'b1;
    end
    idle(10);

    req = "R8"; mp_en = 1'b1;
    send_frame(3, 8'h9A, 1'b1, 1'b1, -1); clear_ri();
    node_addr = 8'h56; node_mask = 8'hFC;
    send_frame(2, 8'h55, 1'b1, 1'b1, -1); clear_ri();
    send_frame(2, 8'h46, 1'b1, 1'b1, -1);
    send_frame(2, 8'h57, 1'b1, 1'b1, -1); clear_ri();

    req = "R9"; send_frame(2, 8'hFE, 1'b1, 1'b1, -1); clear_ri();
    node_addr = 8'hF1; node_mask = 8'hFA;
    send_frame(3, 8'hFB, 1'b1, 1'b1, -1); clear_ri();
    send_frame(3, 8'hF3, 1'b1, 1'b1, -1);

    req = "R10"; send_frame(2, 8'hF1, 1'b0, 1'b1, -1);
    send_frame(2, 8'hF0, 1'b1, 1'b1, -1); clear_ri();

    req = "R11"; send_frame(1, 8'hF4, 1'b0, 1'b1, -1); clear_ri();
    send_frame(1, 8'hF5, 1'b0, 1'b0, -1);
    send_frame(1, 8'h12, 1'b0, 1'b1, -1);

    req = "R12"; send_frame(0, 8'h00, 1'b1, 1'b1, -1);
    mp_en = 1'b0; send_frame(0, 8'h3A, 1'b0, 1'b1, -1);

    req = "R13"; send_frame(1, 8'h6B, 1'b0, 1'b1, -1);
    send_frame(1, 8'h00, 1'b0, 1'b1, -1);
    clear_ri();
    send_frame(2, 8'hE7, 1'b1, 1'b1, -1); clear_ri();
    idle(6);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule